// File: doc/BRIEF.md
# Masked Local-Bus Interrupt Controller

This block gathers sixteen level-sensitive interrupt lines from local-bus peripherals and presents one interrupt request to the processor. Each line's level is captured into a source register on every clock. The source register is combined with an enable mask that software writes. The request output is high while at least one captured source is also enabled.

Software reaches the controller through a small 16-bit register port. A read at the vector offset returns a code that names the lowest-numbered source that is both pending and enabled. The code is `(index + 1) << 2`, and zero means nothing is pending. A second offset holds the enable mask and can be read and written. Sources have no acknowledge: a peripheral withdraws its request by dropping its line. The mask comes out of reset with only source 4 enabled.

Top module: `lbus_irq_ctrl`

## Requirements
- R1: On each clock edge, bit i of the source register takes the level of input line i (1 when high, 0 when low). It can be observed through the vector read when the mask enables that bit.
- R2: `irq_o` is high exactly when the source register AND the mask register is non-zero. It is registered, so it follows an input or mask change on the next clock edge.
- R3: A read at byte offset 0x0 returns `(i + 1) << 2`, where i is the lowest-numbered bit set in source AND mask (for example, source 0 gives 0x0004 and source 15 gives 0x0040).
- R4: A read at byte offset 0x0 returns 0x0000 when source AND mask is zero.
- R5: Byte offset 0x2 reads the 16-bit mask. A write there replaces the mask on the next clock edge, and `irq_o` is re-evaluated with the new mask on that same edge.
- R6: While reset is applied, the mask is 0x0010, the sources are 0 and `irq_o` is low.
- R7: A read at any offset other than 0x0 and 0x2 returns 0x0000. A write at any offset other than 0x2, including 0x0, leaves the mask unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| irq_lvl_i | input | 16 | Level interrupt lines, one per source |
| reg_addr_i | input | 4 | Byte offset of the register access |
| reg_we_i | input | 1 | Write strobe for the register port |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Read data for `reg_addr_i`, from registered state |
| irq_o | output | 1 | Combined interrupt request to the processor |

## Verification
The bench targets the vector encoding when several enabled sources are pending at once. A priority encoder that scans from the wrong end would return the highest index, and one that drops the +1 would return zero for source 0, which software would read as nothing pending. It writes the vector offset and the odd or unused offsets and then reads the mask back, which exposes a decoder that ignores some address bits. It clears the mask while sources stay high to check that the request falls one edge later. It also drives all lines high with the reset mask, so a wrong reset value would change the vector or leave the request low.

// File: rtl/lbic_pkg.sv
package lbic_pkg;
  // Byte offsets of the register port. Software depends on these.
  localparam logic [3:0] OFS_VECTOR = 4'h0;
  localparam logic [3:0] OFS_ENABLE = 4'h2;

  typedef enum logic [1:0] {
    SEL_VECTOR = 2'd0,
    SEL_ENABLE = 2'd1,
    SEL_NONE   = 2'd2
  } reg_sel_e;
endpackage

// File: rtl/lbic_rst_sync.sv
module lbic_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/lbic_src_capture.sv
module lbic_src_capture #(
  parameter int unsigned N_SRC = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] lvl_i,
  output logic [N_SRC-1:0] src_q_o
);
  logic [N_SRC-1:0] src_d, src_q;

  always_comb src_d = lvl_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) src_q <= '0;
    else        src_q <= src_d;
  end

  assign src_q_o = src_q;

  // R1
  src_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (src_q == $past(lvl_i)));
endmodule

// File: rtl/lbic_mask_reg.sv
module lbic_mask_reg
  import lbic_pkg::*;
#(
  parameter int unsigned N_SRC    = 16,
  parameter int unsigned ADDR_W   = 4,
  parameter logic [N_SRC-1:0] MASK_RST = 16'h0010
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [N_SRC-1:0]  wdata_i,
  output reg_sel_e          sel_o,
  output logic [N_SRC-1:0]  mask_q_o,
  output logic [N_SRC-1:0]  mask_d_o
);
  reg_sel_e         sel;
  logic             mask_en;
  logic [N_SRC-1:0] mask_d, mask_q;

  always_comb begin
    if (addr_i == ADDR_W'(OFS_VECTOR))      sel = SEL_VECTOR;
    else if (addr_i == ADDR_W'(OFS_ENABLE)) sel = SEL_ENABLE;
    else                                    sel = SEL_NONE;
  end

  always_comb begin
    mask_en = we_i && (sel == SEL_ENABLE);
    mask_d  = mask_en ? wdata_i : mask_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= MASK_RST;
    else if (mask_en) mask_q <= mask_d;
  end

  assign sel_o    = sel;
  assign mask_q_o = mask_q;
  assign mask_d_o = mask_d;

  // R7
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(we_i && addr_i == ADDR_W'(OFS_ENABLE)) |=> $stable(mask_q));

  // R5
  mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && addr_i == ADDR_W'(OFS_ENABLE)) |=> (mask_q == $past(wdata_i)));
endmodule

// File: rtl/lbic_lowest_enc.sv
module lbic_lowest_enc #(
  parameter int unsigned N_SRC = 16,
  parameter int unsigned VEC_W = 16
) (
  input  logic [N_SRC-1:0] pend_i,
  output logic [VEC_W-1:0] vec_o
);
  always_comb begin
    vec_o = '0;
    // Scan down so the lowest set bit is the last one assigned.
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (pend_i[i]) vec_o = VEC_W'((i + 1) << 2);
    end
  end
endmodule

// File: rtl/lbus_irq_ctrl.sv
module lbus_irq_ctrl
  import lbic_pkg::*;
#(
  parameter int unsigned N_SRC  = 16,
  parameter int unsigned ADDR_W = 4,
  parameter logic [N_SRC-1:0] MASK_RST = 16'h0010
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SRC-1:0]  irq_lvl_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic              reg_we_i,
  input  logic [N_SRC-1:0]  reg_wdata_i,
  output logic [N_SRC-1:0]  reg_rdata_o,
  output logic              irq_o
);
  localparam int unsigned VEC_W = N_SRC;

  logic             rst_sync_n;
  logic [N_SRC-1:0] src_q, mask_q, mask_d, pend;
  logic [VEC_W-1:0] vec;
  reg_sel_e         sel;
  logic             irq_d, irq_q;

  lbic_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  lbic_src_capture #(.N_SRC(N_SRC)) u_src (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .lvl_i   (irq_lvl_i),
    .src_q_o (src_q)
  );

  lbic_mask_reg #(.N_SRC(N_SRC), .ADDR_W(ADDR_W), .MASK_RST(MASK_RST)) u_mask (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .addr_i   (reg_addr_i),
    .we_i     (reg_we_i),
    .wdata_i  (reg_wdata_i),
    .sel_o    (sel),
    .mask_q_o (mask_q),
    .mask_d_o (mask_d)
  );

  assign pend = src_q & mask_q;

  lbic_lowest_enc #(.N_SRC(N_SRC), .VEC_W(VEC_W)) u_enc (
    .pend_i (pend),
    .vec_o  (vec)
  );

  // Request follows the values the source and mask registers take on this edge.
  always_comb irq_d = |(irq_lvl_i & mask_d);

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) irq_q <= 1'b0;
    else             irq_q <= irq_d;
  end

  always_comb begin
    unique case (sel)
      SEL_VECTOR: reg_rdata_o = vec;
      SEL_ENABLE: reg_rdata_o = mask_q;
      default:    reg_rdata_o = '0;
    endcase
  end

  assign irq_o = irq_q;

  // R2
  irq_match_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    irq_o == (pend != '0));

  // R4
  vec_zero_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (pend == '0) |-> (vec == '0));

  // R3
  vec_code_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (pend != '0) |-> (vec != '0 && vec[1:0] == 2'b00));
endmodule

// File: tb/lbus_irq_ctrl_tb.sv
module lbus_irq_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] lvl;
  logic [3:0]  addr;
  logic        we;
  logic [15:0] wdata;
  logic [15:0] rdata;
  logic        irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // Reference state
  logic [15:0] m_src  = 16'h0000;
  logic [15:0] m_mask = 16'h0010;
  logic        m_irq  = 1'b0;

  always #2 clk = ~clk;

  lbus_irq_ctrl u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .irq_lvl_i   (lvl),
    .reg_addr_i  (addr),
    .reg_we_i    (we),
    .reg_wdata_i (wdata),
    .reg_rdata_o (rdata),
    .irq_o       (irq)
  );

  function automatic logic [15:0] model_vec(input logic [15:0] p);
    for (int i = 0; i < 16; i++) if (p[i]) return 16'((i + 1) * 4);
    return 16'h0000;
  endfunction

  function automatic logic [15:0] model_read(input logic [3:0] a);
    if (a == 4'h0) return model_vec(m_src & m_mask);
    if (a == 4'h2) return m_mask;
    return 16'h0000;
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h at %0t", tag, act, exp, $time);
    end
  endtask

  // One cycle: drive after the falling edge, compare, then advance the model.
  task automatic step(input logic [15:0] l, input logic [3:0] a, input logic w,
                      input logic [15:0] d, input string tag);
    string t;
    @(negedge clk);
    lvl = l; addr = a; we = w; wdata = d;
    #1;
    if (tag != "") t = tag;
    else if (a == 4'h0) t = ((m_src & m_mask) != 0) ? "R3" : "R4";
    else if (a == 4'h2) t = "R5";
    else t = "R7";
    check(t, rdata, model_read(a));
    check("R2", {15'd0, irq}, {15'd0, m_irq});
    @(posedge clk);
    m_src = lvl;
    if (we && addr == 4'h2) m_mask = wdata;
    m_irq = (m_src & m_mask) != 0;
  endtask

  initial begin
    rst_n = 1'b0; lvl = '0; addr = 4'h2; we = 1'b0; wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    lvl = 16'hFFFF;
    #1 check("R6", rdata, 16'h0010);
    check("R6", {15'd0, irq}, 16'h0000);
    addr = 4'h0;
    #1 check("R6", rdata, 16'h0000);
    lvl = '0;
    rst_n = 1'b1;
    repeat (4) step(16'h0000, 4'h2, 1'b0, 16'h0, "R6");

    // Reset mask enables only source 4: all lines high gives code 20.
    step(16'hFFFF, 4'h0, 1'b0, 16'h0, "");
    step(16'hFFFF, 4'h0, 1'b0, 16'h0, "R6");
    step(16'hFFEF, 4'h0, 1'b0, 16'h0, "R4");
    step(16'hFFEF, 4'h0, 1'b0, 16'h0, "R4");

    // Enable everything, walk each source alone.
    step(16'h0000, 4'h2, 1'b1, 16'hFFFF, "");
    for (int i = 0; i < 16; i++) begin
      step(16'(1 << i), 4'h0, 1'b0, 16'h0, "R1");
      step(16'(1 << i), 4'h0, 1'b0, 16'h0, "R1");
    end

    // Several pending: the lowest enabled one wins.
    step(16'h0000, 4'h2, 1'b1, 16'hFF00, "");
    step(16'hA8F1, 4'h0, 1'b0, 16'h0, "");
    step(16'hA8F1, 4'h0, 1'b0, 16'h0, "R3");
    step(16'h8001, 4'h0, 1'b0, 16'h0, "R3");
    step(16'h8001, 4'h0, 1'b0, 16'h0, "R3");

    // Clearing the mask drops the request on the next edge.
    step(16'h8001, 4'h2, 1'b1, 16'h0000, "");
    step(16'h8001, 4'h2, 1'b0, 16'h0, "R5");
    step(16'h8001, 4'h0, 1'b0, 16'h0, "R4");

    // Writes at other offsets must not reach the mask.
    step(16'h0000, 4'h2, 1'b1, 16'h1234, "");
    for (int a = 0; a < 16; a++) begin
      if (a != 2) begin
        step(16'hFFFF, 4'(a), 1'b1, 16'hDEAD, "R7");
        step(16'hFFFF, 4'h2, 1'b0, 16'h0, "R7");
      end
    end

    // Mixed traffic.
    for (int n = 0; n < 3000; n++) begin
      logic [3:0] ra;
      int sel;
      sel = $urandom_range(0, 9);
      ra = (sel < 5) ? 4'h0 : (sel < 8) ? 4'h2 : 4'($urandom_range(0, 15));
      step(16'($urandom) & 16'($urandom), ra, ($urandom_range(0, 7) == 0),
           16'($urandom), "");
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule